// File: doc/BRIEF.md
# Multichannel ADC Sample Playback Generator

This block sits between the ADC capture registers of a multichannel digitizer and its trigger-processing path. Each channel owns a small pattern memory that a host fills through a word-write port while the block is idle. When an external playback gate is asserted, the block sends stored samples to the trigger path in place of the live ADC samples, one per sample clock. The trigger logic downstream sees the same data format either way, so it cannot tell replayed data from real conversions. This lets the trigger hardware be exercised with known pulse shapes.

The gate's length decides how many stored samples are replayed. The gate is synchronized into the sample clock domain. Its rising edge restarts the read pointer at location 0. The pointer then advances once per clock and holds at the last location until the gate drops, at which point live data resumes. Each channel has an enable bit, so a chosen subset can replay while the other channels keep passing live samples. Readout triggering is handled elsewhere and does not interact with this block.

Top module: `adc_playback_gen`

## Requirements
- R1: While `rstN` is low, `outSamples`, `playActive` and `wrErr` are all zero. `wrErr` is cleared only by reset.
- R2: While playback is inactive, each channel's output slice equals that channel's `liveSamples` slice from the previous clock edge, delayed by one register.
- R3: `playGate` passes through a two-flop synchronizer. `playActive` goes high at the second rising edge after `playGate` goes high, and goes low at the second rising edge after `playGate` goes low.
- R4: At the first edge where `playActive` is seen high, an enabled channel outputs memory location 0 at its register. At each following edge it outputs the next location.
- R5: While the gate stays high after location 31 (DEPTH-1) has been output, every further output repeats location 31.
- R6: One edge after `playActive` is seen low, each output takes the live sample again.
- R7: A channel whose `chanEnable` bit (bit c for channel c) is low outputs live data even during playback.
- R8: A host write (`hostWrEn` high) at an edge where playback is inactive stores `hostData` at location `hostAddr` of channel `hostChan`.
- R9: A host write at an edge where `playActive` is high leaves every memory unchanged and sets the sticky flag `wrErr` from the next edge on.
- R10: A new rising edge of the synchronized gate restarts playback at location 0, even after a gap of one cycle.
- R11: The channels hold independent waveforms. Channel c's output during playback comes only from channel c's memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host pattern-write strobe |
| hostChan | input | 4 | Channel selected by the host write |
| hostAddr | input | 5 | Pattern location selected by the host write |
| hostData | input | 12 | Sample value to store |
| chanEnable | input | 16 | Per-channel playback participation, bit c for channel c |
| playGate | input | 1 | Asynchronous external playback gate |
| liveSamples | input | 192 | Live ADC samples, channel c at bits [12c+11:12c] |
| outSamples | output | 192 | Samples to the trigger path, same packing |
| playActive | output | 1 | Synchronized gate, high while replaying |
| wrErr | output | 1 | Sticky flag for a host write rejected during playback |

## Verification
The bench checks the pipeline alignment of the gate's rising edge. A design that dropped or added a synchronizer stage, or started at location 1, would show the wrong first sample or every sample shifted by one. Long gates check that the pointer saturates at location 31, since a wrapping pointer would restart the waveform. Short low gaps check that the pointer restarts, since a design that continued the old count would output mid-pattern samples. Host writes during playback are followed by a replay of the same locations, so a design that still stored them shows changed samples. Mixed enable masks catch a design that replays disabled channels or reads a neighbour's memory.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
  localparam int NUM_CH_DEF   = 16;
  localparam int DEPTH_DEF    = 32;
  localparam int SAMPLE_W_DEF = 12;
  localparam int SYNC_DEF     = 2;

  // strobes from control to datapath; addresses travel on their own port
  typedef struct packed {
    logic playing;    // replay stored samples this cycle
    logic wrAccept;   // host write may land in memory
    logic wrReject;   // host write arrived during playback
  } pbkStrobes_t;
endpackage

// File: rtl/pbk_gate_sync.sv
module pbk_gate_sync #(
  parameter int STAGES = pbk_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateIn,
  output logic gateSync,
  output logic gateRise
);
  logic [STAGES-1:0] chain;
  logic              gatePrev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= gateIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) gatePrev <= 1'b0;
    else       gatePrev <= chain[STAGES-1];
  end

  assign gateSync = chain[STAGES-1];
  assign gateRise = chain[STAGES-1] & ~gatePrev;
endmodule

// File: rtl/pbk_ctrl.sv
module pbk_ctrl
  import pbk_pkg::*;
#(
  parameter int DEPTH = DEPTH_DEF,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          gateSync,
  input  logic          gateRise,
  input  logic          hostWrEn,
  output pbkStrobes_t   strobes,
  output logic [AW-1:0] rdAddr,
  output logic          wrErr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] nextPtr;

  // the rising edge restarts the pattern at location 0
  always_comb begin
    rdAddr = gateRise ? '0 : nextPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPtr <= '0;
    end else if (gateSync) begin
      nextPtr <= (rdAddr == LAST) ? LAST : rdAddr + 1'b1;
    end
  end

  always_comb begin
    strobes.playing  = gateSync;
    strobes.wrAccept = hostWrEn & ~gateSync;
    strobes.wrReject = hostWrEn & gateSync;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 wrErr <= 1'b0;
    else if (strobes.wrReject) wrErr <= 1'b1;
  end
endmodule

// File: rtl/pbk_datapath.sv
module pbk_datapath
  import pbk_pkg::*;
#(
  parameter int NUM_CH   = NUM_CH_DEF,
  parameter int DEPTH    = DEPTH_DEF,
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(NUM_CH),
  localparam int BUS_W   = NUM_CH * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbkStrobes_t       strobes,
  input  logic [AW-1:0]     rdAddr,
  input  logic [CW-1:0]     hostChan,
  input  logic [AW-1:0]     hostAddr,
  input  logic [SAMPLE_W-1:0] hostData,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic [BUS_W-1:0]  liveSamples,
  output logic [BUS_W-1:0]  outSamples
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [SAMPLE_W-1:0] patMem [DEPTH];
      logic [SAMPLE_W-1:0] stored;
      logic [SAMPLE_W-1:0] sampleReg;

      always_ff @(posedge clk) begin
        if (strobes.wrAccept && hostChan == CW'(c)) begin
          patMem[hostAddr] <= hostData;
        end
      end

      assign stored = patMem[rdAddr];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          sampleReg <= '0;
        end else if (strobes.playing && chanEnable[c]) begin
          sampleReg <= stored;
        end else begin
          sampleReg <= liveSamples[c*SAMPLE_W +: SAMPLE_W];
        end
      end

      assign outSamples[c*SAMPLE_W +: SAMPLE_W] = sampleReg;
    end
  endgenerate
endmodule

// File: rtl/adc_playback_gen.sv
module adc_playback_gen
  import pbk_pkg::*;
#(
  parameter int NUM_CH      = NUM_CH_DEF,
  parameter int DEPTH       = DEPTH_DEF,
  parameter int SAMPLE_W    = SAMPLE_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF,
  localparam int AW         = $clog2(DEPTH),
  localparam int CW         = $clog2(NUM_CH),
  localparam int BUS_W      = NUM_CH * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [CW-1:0]       hostChan,
  input  logic [AW-1:0]       hostAddr,
  input  logic [SAMPLE_W-1:0] hostData,
  input  logic [NUM_CH-1:0]   chanEnable,
  input  logic                playGate,
  input  logic [BUS_W-1:0]    liveSamples,
  output logic [BUS_W-1:0]    outSamples,
  output logic                playActive,
  output logic                wrErr
);
  logic          gateSync;
  logic          gateRise;
  pbkStrobes_t   strobes;
  logic [AW-1:0] rdAddr;

  pbk_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .gateIn   (playGate),
    .gateSync (gateSync),
    .gateRise (gateRise)
  );

  pbk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .gateSync (gateSync),
    .gateRise (gateRise),
    .hostWrEn (hostWrEn),
    .strobes  (strobes),
    .rdAddr   (rdAddr),
    .wrErr    (wrErr)
  );

  pbk_datapath #(
    .NUM_CH   (NUM_CH),
    .DEPTH    (DEPTH),
    .SAMPLE_W (SAMPLE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rdAddr      (rdAddr),
    .hostChan    (hostChan),
    .hostAddr    (hostAddr),
    .hostData    (hostData),
    .chanEnable  (chanEnable),
    .liveSamples (liveSamples),
    .outSamples  (outSamples)
  );

  assign playActive = gateSync;
endmodule

// File: rtl/adc_playback_gen_chk.sv
module adc_playback_gen_chk #(
  parameter int NUM_CH   = 16,
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 12,
  localparam int AW      = $clog2(DEPTH),
  localparam int BUS_W   = NUM_CH * SAMPLE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             playGate,
  input logic             hostWrEn,
  input logic [BUS_W-1:0] liveSamples,
  input logic [BUS_W-1:0] outSamples,
  input logic             playActive,
  input logic             wrErr,
  input logic [AW-1:0]    rdAddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0] sinceReset;
  always_ff @(posedge clk) begin
    if (!rstN)                  sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R3
  gate_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2) |-> (playActive == $past(playGate, 2)));

  // R2
  live_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !playActive |=> (outSamples == $past(liveSamples)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playActive && $past(playActive) && $past(rdAddr) != LAST)
      |-> (rdAddr == AW'($past(rdAddr) + 1'b1)));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playActive && $past(playActive) && $past(rdAddr) == LAST)
      |-> (rdAddr == LAST));

  // R9
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && playActive) |=> wrErr);

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(wrErr));
endmodule

bind adc_playback_gen adc_playback_gen_chk #(
  .NUM_CH   (NUM_CH),
  .DEPTH    (DEPTH),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .playGate    (playGate),
  .hostWrEn    (hostWrEn),
  .liveSamples (liveSamples),
  .outSamples  (outSamples),
  .playActive  (playActive),
  .wrErr       (wrErr),
  .rdAddr      (rdAddr)
);

// File: tb/adc_playback_gen_bench.sv
module adc_playback_gen_bench;
  localparam int CLK_PERIOD = 4;
  localparam int NCH = 16;
  localparam int DEPTH = 32;
  localparam int SW = 12;
  localparam int BW = NCH * SW;

  logic          clk;
  logic          rstN;
  logic          hostWrEn;
  logic [3:0]    hostChan;
  logic [4:0]    hostAddr;
  logic [SW-1:0] hostData;
  logic [NCH-1:0] chanEnable;
  logic          playGate;
  logic [BW-1:0] liveSamples;
  logic [BW-1:0] outSamples;
  logic          playActive;
  logic          wrErr;

  adc_playback_gen u_adc_playback_gen (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostChan(hostChan),
    .hostAddr(hostAddr), .hostData(hostData), .chanEnable(chanEnable),
    .playGate(playGate), .liveSamples(liveSamples), .outSamples(outSamples),
    .playActive(playActive), .wrErr(wrErr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // requirement-level model state
  logic [SW-1:0] mMem [NCH][DEPTH];
  bit ms1, ms2, mPrev, mErr;
  int mPtr;
  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  function automatic logic [BW-1:0] randLive();
    logic [BW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*SW +: SW] = SW'($urandom);
    return v;
  endfunction

  function automatic logic [BW-1:0] expectOut(input bit rise);
    logic [BW-1:0] v;
    int rd = rise ? 0 : mPtr;
    for (int c = 0; c < NCH; c++)
      v[c*SW +: SW] = (ms2 && chanEnable[c]) ? mMem[c][rd] : liveSamples[c*SW +: SW];
    return v;
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    ms1 = 0; ms2 = 0; mPrev = 0; mErr = 0; mPtr = 0;
  endtask

  // one clock: predict from inputs held across the edge, then compare
  task automatic step(input string tag);
    bit rise = ms2 && !mPrev;
    int rd = rise ? 0 : mPtr;
    logic [BW-1:0] exp = expectOut(rise);
    if (hostWrEn) begin
      if (ms2) mErr = 1;
      else     mMem[hostChan][hostAddr] = hostData;
    end
    if (ms2) mPtr = (rd == DEPTH-1) ? DEPTH-1 : rd + 1;
    mPrev = ms2; ms2 = ms1; ms1 = playGate;
    @(posedge clk);
    @(negedge clk);
    check(tag, outSamples, exp);
    check("R3", BW'(playActive), BW'(ms2));
    check("R9", BW'(wrErr), BW'(mErr));
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      liveSamples = randLive();
      step(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; hostWrEn = 0; hostChan = 0; hostAddr = 0; hostData = 0;
    chanEnable = '1; playGate = 0; liveSamples = randLive();
    repeat (3) @(negedge clk);
    check("R1", outSamples, '0);
    check("R1", BW'({playActive, wrErr}), '0);
    rstN = 1;
    modelReset();

    // R8: load a distinct waveform into every channel while idle
    hostWrEn = 1;
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < DEPTH; a++) begin
        hostChan = 4'(c); hostAddr = 5'(a); hostData = SW'($urandom);
        liveSamples = randLive();
        step("R8");
      end
    hostWrEn = 0;

    run("R2", 20);

    // full replay: sync latency, per-channel shapes, then saturation
    playGate = 1;
    run("R3", 3);
    run("R11", 32);
    run("R5", 15);
    playGate = 0;
    run("R6", 6);

    // R7: a subset of channels replays
    chanEnable = 16'hA5C3;
    playGate = 1;
    run("R7", 12);
    playGate = 0;
    run("R7", 5);
    chanEnable = '1;

    // R9: writes during playback are dropped and flagged
    playGate = 1;
    run("R9", 3);
    hostWrEn = 1;
    for (int i = 0; i < 4; i++) begin
      hostChan = 4'($urandom); hostAddr = 5'(i); hostData = SW'($urandom);
      liveSamples = randLive();
      step("R9");
    end
    hostWrEn = 0;
    playGate = 0;
    run("R9", 4);
    playGate = 1;
    run("R9", 36);
    playGate = 0;
    run("R9", 4);

    // R10: restarts after short low gaps
    playGate = 1; run("R10", 8);
    playGate = 0; run("R10", 1);
    playGate = 1; run("R10", 10);
    playGate = 0; run("R10", 2);
    playGate = 1; run("R10", 6);
    playGate = 0; run("R10", 5);

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(7) == 0) playGate = ~playGate;
      hostWrEn = ($urandom_range(5) == 0);
      hostChan = 4'($urandom); hostAddr = 5'($urandom); hostData = SW'($urandom);
      if ($urandom_range(19) == 0) chanEnable = NCH'($urandom);
      liveSamples = randLive();
      step(ms2 ? "R4" : "R2");
    end
    hostWrEn = 0;

    // R1: reset clears the sticky flag and outputs
    rstN = 0;
    repeat (2) @(negedge clk);
    check("R1", outSamples, '0);
    check("R1", BW'({playActive, wrErr}), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule